// File: doc/BRIEF.md
# GPIO Port with Per-Pin Edge Capture

A general-purpose I/O port of up to 32 pins, attached to a simple single-cycle register bus. Software sets each pin's direction, drives output values, reads pin levels and enables interrupts pin by pin. Input levels pass through a two-stage synchronizer. In the edge modes, each detected event sets a sticky capture bit that software clears by writing a one to it. A single interrupt output combines the enabled sources.

The event type is fixed when the block is built, through the `TRIG` parameter. It can be rising edge, falling edge, either edge, or level high. In level-high mode no capture state is kept, and the interrupt follows the synchronized pin levels gated by the enable bits. The block supplies separate output-value and output-enable vectors, so the pad cells stay outside it.

Top module: `gpio_edge_port`

## Requirements
- R1: While `rst_ni` is low and after it rises, the direction, enable, capture and output-value registers hold zero. `pin_o`, `pin_oe_o` and `irq_o` are all zero.
- R2: Word index `addr_i[ADDR_W-1:2]` selects a register: 0 is the pin level / output value, 1 is direction, 2 is interrupt enable, 3 is capture. Address bits [1:0] are ignored. Bit i of each register belongs to pin i, and read bits at or above `N_PINS` are zero.
- R3: A write to word 1 sets `pin_oe_o` to the written low `N_PINS` bits on the next clock edge, and word 1 reads the same value back. A bit of 1 makes the pin an output.
- R4: A write to word 0 sets `pin_o` on the next clock edge. A read of word 0 returns the levels on `pin_i`, whatever the direction settings. A change on `pin_i` becomes visible after the second rising clock edge.
- R5: Reads of word indices of 4 and above return zero. Writes to them leave every register and output unchanged.
- R6: `TRIG` encodes 0 = rising, 1 = falling, 2 = both edges, 3 = level high. In modes 0 to 2, a matching transition on pin i sets capture bit i after the third rising clock edge that follows the pin change. In mode 3 the capture register always reads zero.
- R7: Writing word 3 clears each capture bit whose written bit is 1 and leaves the bits written with 0 unchanged.
- R8: When a new event on a pin and a clearing write to its capture bit land on the same clock edge, the bit ends set.
- R9: In modes 0 to 2, `irq_o` is 1 exactly when some capture bit and its enable bit are both 1. It follows a register write without extra delay.
- R10: In mode 3, `irq_o` is 1 exactly when some synchronized pin level and its enable bit are both 1.
- R11: With every enable bit at zero, `irq_o` stays low whatever the pins and capture bits hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access valid this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle of a read request |
| pin_i | input | N_PINS | Pin levels from the pads |
| pin_o | output | N_PINS | Output values to the pads |
| pin_oe_o | output | N_PINS | Output enables to the pads |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume a single-cycle bus where `we_i` and `addr_i` are meaningful only when `req_i` is high. They also assume `pin_i` holds low through reset, so releasing reset cannot look like a rising edge. The stimulus drives the bus and pins only on falling clock edges, holds every pin at zero during reset, and issues each bus access for exactly one cycle. Four builds, one per event type, share the same pins and bus, so a single sweep shows each pin's transition captured in one mode and ignored in another.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  typedef enum logic [1:0] {
    TRIG_RISE  = 2'd0,
    TRIG_FALL  = 2'd1,
    TRIG_BOTH  = 2'd2,
    TRIG_LEVEL = 2'd3
  } trig_e;

  localparam int unsigned REG_W    = 32;
  localparam int unsigned IDX_DATA = 0;
  localparam int unsigned IDX_DIR  = 1;
  localparam int unsigned IDX_MASK = 2;
  localparam int unsigned IDX_CAP  = 3;
  localparam int unsigned N_REGS   = 4;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_event.sv
module gpio_event
  import gpio_edge_pkg::*;
#(
  parameter int unsigned W    = 8,
  parameter trig_e       TRIG = TRIG_RISE
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] cap_o
);
  if (TRIG == TRIG_LEVEL) begin : g_level
    // no capture state in level mode
    logic unused_lvl;
    assign unused_lvl = ^{clk_i, rst_ni, lvl_i, clr_i};
    assign cap_o      = '0;
  end else begin : g_edge
    logic [W-1:0] prev_q, cap_q, evt;

    if (TRIG == TRIG_RISE) begin : g_rise
      assign evt = lvl_i & ~prev_q;
    end else if (TRIG == TRIG_FALL) begin : g_fall
      assign evt = ~lvl_i & prev_q;
    end else begin : g_both
      assign evt = lvl_i ^ prev_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q <= '0;
        cap_q  <= '0;
      end else begin
        prev_q <= lvl_i;
        // new event wins over a same-cycle clear
        cap_q  <= (cap_q & ~clr_i) | evt;
      end
    end

    assign cap_o = cap_q;
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_edge_pkg::*;
#(
  parameter int unsigned W  = 8,
  parameter int unsigned AW = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  input  logic [W-1:0]     lvl_i,
  input  logic [W-1:0]     cap_i,
  output logic [W-1:0]     dout_o,
  output logic [W-1:0]     dir_o,
  output logic [W-1:0]     mask_o,
  output logic [W-1:0]     clr_o
);
  localparam int unsigned IW = AW - 2;

  logic [IW-1:0] idx;
  logic          wr_data, wr_dir, wr_mask, wr_cap;
  logic [W-1:0]  dout_q, dir_q, mask_q;

  assign idx     = addr_i[AW-1:2];
  assign wr_data = req_i & we_i & (idx == IW'(IDX_DATA));
  assign wr_dir  = req_i & we_i & (idx == IW'(IDX_DIR));
  assign wr_mask = req_i & we_i & (idx == IW'(IDX_MASK));
  assign wr_cap  = req_i & we_i & (idx == IW'(IDX_CAP));

  logic unused_lo;
  assign unused_lo = ^addr_i[1:0];

  if (W < REG_W) begin : g_pad
    logic unused_hi;
    assign unused_hi = ^wdata_i[REG_W-1:W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q <= '0;
      dir_q  <= '0;
      mask_q <= '0;
    end else begin
      if (wr_data) dout_q <= wdata_i[W-1:0];
      if (wr_dir)  dir_q  <= wdata_i[W-1:0];
      if (wr_mask) mask_q <= wdata_i[W-1:0];
    end
  end

  assign clr_o = wr_cap ? wdata_i[W-1:0] : '0;

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      if (idx == IW'(IDX_DATA))      rdata_o = REG_W'(lvl_i);
      else if (idx == IW'(IDX_DIR))  rdata_o = REG_W'(dir_q);
      else if (idx == IW'(IDX_MASK)) rdata_o = REG_W'(mask_q);
      else if (idx == IW'(IDX_CAP))  rdata_o = REG_W'(cap_i);
    end
  end

  assign dout_o = dout_q;
  assign dir_o  = dir_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
  import gpio_edge_pkg::*;
#(
  parameter int unsigned N_PINS = 32,
  parameter int unsigned ADDR_W = 4,
  parameter trig_e       TRIG   = TRIG_RISE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [N_PINS-1:0] pin_i,
  output logic [N_PINS-1:0] pin_o,
  output logic [N_PINS-1:0] pin_oe_o,
  output logic              irq_o
);
  if (N_PINS == 0 || N_PINS > REG_W) begin : g_bad_width
    $error("N_PINS must be 1..32");
  end
  if (ADDR_W < 4) begin : g_bad_addr
    $error("ADDR_W must cover four words");
  end

  logic [N_PINS-1:0] lvl_w, cap_w, clr_w, mask_w, dout_w, dir_w;

  gpio_sync #(.W(N_PINS), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (lvl_w)
  );

  gpio_event #(.W(N_PINS), .TRIG(TRIG)) u_event (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (lvl_w),
    .clr_i (clr_w),
    .cap_o (cap_w)
  );

  gpio_regs #(.W(N_PINS), .AW(ADDR_W)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .we_i   (we_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .rdata_o(rdata_o),
    .lvl_i  (lvl_w),
    .cap_i  (cap_w),
    .dout_o (dout_w),
    .dir_o  (dir_w),
    .mask_o (mask_w),
    .clr_o  (clr_w)
  );

  if (TRIG == TRIG_LEVEL) begin : g_irq_level
    assign irq_o = |(lvl_w & mask_w);
  end else begin : g_irq_edge
    assign irq_o = |(cap_w & mask_w);
  end

  assign pin_o    = dout_w;
  assign pin_oe_o = dir_w;
endmodule

// File: rtl/gpio_edge_port_chk.sv
module gpio_edge_port_chk
  import gpio_edge_pkg::*;
#(
  parameter int unsigned N_PINS = 32,
  parameter int unsigned ADDR_W = 4,
  parameter trig_e       TRIG   = TRIG_RISE
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic [31:0]       rdata_o,
  input logic [N_PINS-1:0] pin_o,
  input logic [N_PINS-1:0] pin_oe_o,
  input logic              irq_o,
  input logic [N_PINS-1:0] mask_q,
  input logic [N_PINS-1:0] cap_q
);
  localparam int unsigned IW = ADDR_W - 2;

  logic [IW-1:0]     idx;
  logic              unmapped;
  logic [N_PINS-1:0] clr_req, keep;

  assign idx      = addr_i[ADDR_W-1:2];
  assign unmapped = (idx > IW'(3));
  assign clr_req  = (req_i && we_i && idx == IW'(IDX_CAP)) ? wdata_i[N_PINS-1:0] : '0;
  assign keep     = cap_q & ~clr_req;

  a_r3_dir_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && idx == IW'(IDX_DIR)) |=> (pin_oe_o == $past(wdata_i[N_PINS-1:0])));

  a_r4_out_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && idx == IW'(IDX_DATA)) |=> (pin_o == $past(wdata_i[N_PINS-1:0])));

  a_r5_hole_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && unmapped) |-> (rdata_o == '0));

  a_r5_hole_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && unmapped) |=> ($stable(pin_o) && $stable(pin_oe_o) && $stable(mask_q)));

  a_r7_sticky_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((cap_q & $past(keep)) == $past(keep)));

  a_r11_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |-> !irq_o);

  if (TRIG == TRIG_LEVEL) begin : g_lvl_chk
    a_r6_level_no_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cap_q == '0));
  end
endmodule

bind gpio_edge_port gpio_edge_port_chk #(
  .N_PINS(N_PINS),
  .ADDR_W(ADDR_W),
  .TRIG  (TRIG)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .pin_o   (pin_o),
  .pin_oe_o(pin_oe_o),
  .irq_o   (irq_o),
  .mask_q  (mask_w),
  .cap_q   (cap_w)
);

// File: tb/gpio_edge_port_bench.sv
`timescale 1ns/1ps
module gpio_edge_port_bench;
  import gpio_edge_pkg::*;

  localparam int unsigned NP = 8;
  localparam int unsigned AW = 5;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [NP-1:0] pins = '0;

  logic [31:0]   rd_rise, rd_fall, rd_both, rd_lvl;
  logic [NP-1:0] po_rise, po_fall, po_both, po_lvl;
  logic [NP-1:0] oe_rise, oe_fall, oe_both, oe_lvl;
  logic          irq_rise, irq_fall, irq_both, irq_lvl;

  logic [31:0] v_rise, v_fall, v_both, v_lvl;
  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  gpio_edge_port #(.N_PINS(NP), .ADDR_W(AW), .TRIG(TRIG_RISE)) u_gpio_edge_port (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rd_rise), .pin_i(pins), .pin_o(po_rise), .pin_oe_o(oe_rise), .irq_o(irq_rise));
  gpio_edge_port #(.N_PINS(NP), .ADDR_W(AW), .TRIG(TRIG_FALL)) u_gpio_edge_port_fall (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rd_fall), .pin_i(pins), .pin_o(po_fall), .pin_oe_o(oe_fall), .irq_o(irq_fall));
  gpio_edge_port #(.N_PINS(NP), .ADDR_W(AW), .TRIG(TRIG_BOTH)) u_gpio_edge_port_both (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rd_both), .pin_i(pins), .pin_o(po_both), .pin_oe_o(oe_both), .irq_o(irq_both));
  gpio_edge_port #(.N_PINS(NP), .ADDR_W(AW), .TRIG(TRIG_LEVEL)) u_gpio_edge_port_lvl (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rd_lvl), .pin_i(pins), .pin_o(po_lvl), .pin_oe_o(oe_lvl), .irq_o(irq_lvl));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1;
    v_rise = rd_rise; v_fall = rd_fall; v_both = rd_both; v_lvl = rd_lvl;
    req = 1'b0;
  endtask

  task automatic caps(input string tag, input logic [31:0] er, input logic [31:0] ef,
                      input logic [31:0] eb);
    rd(5'h0C);
    check({tag, " rise"}, v_rise, er);
    check({tag, " fall"}, v_fall, ef);
    check({tag, " both"}, v_both, eb);
    check({tag, " level R6"}, v_lvl, 32'h0);
  endtask

  task automatic clear_all();
    pins = '0;
    repeat (3) @(negedge clk);
    wr(5'h0C, 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 oe in reset", 32'(oe_rise), 32'h0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    check("R1 pin_o", 32'(po_rise), 32'h0);
    check("R1 pin_oe_o", 32'(oe_both), 32'h0);
    check("R1 irq", {28'h0, irq_rise, irq_fall, irq_both, irq_lvl}, 32'h0);
    rd(5'h04); check("R1 dir", v_rise, 32'h0);
    rd(5'h08); check("R1 mask", v_lvl, 32'h0);
    caps("R1 capture", 32'h0, 32'h0, 32'h0);

    // R3 direction, R2 alias and upper bits
    wr(5'h04, 32'h0000_00A5);
    check("R3 pin_oe_o", 32'(oe_rise), 32'hA5);
    rd(5'h04); check("R3 dir readback", v_rise, 32'hA5);
    rd(5'h07); check("R2 low address bits ignored", v_fall, 32'hA5);
    wr(5'h05, 32'hFFFF_FF5A);
    check("R3 pin_oe_o alias write", 32'(oe_lvl), 32'h5A);
    rd(5'h04); check("R2 upper read bits zero", v_both, 32'h5A);

    // R4 output value
    wr(5'h00, 32'h0000_003C);
    check("R4 pin_o", 32'(po_rise), 32'h3C);
    rd(5'h00); check("R4 data read shows pins not outputs", v_rise, 32'h0);

    // R4 pin level sweep, all 256 patterns; two edges then sample
    for (int v = 0; v < 256; v++) begin
      @(negedge clk);
      pins = NP'(v);
      @(negedge clk);
      rd(5'h00);
      check("R4 pin level read", v_rise, 32'(v));
    end
    // R4 one edge is not enough
    @(negedge clk);
    pins = 8'h00;
    rd(5'h00);
    check("R4 sync latency one edge", v_both, 32'hFF);
    clear_all();
    caps("R7 clear all", 32'h0, 32'h0, 32'h0);

    // R5 unmapped
    wr(5'h10, 32'hFFFF_FFFF);
    wr(5'h1C, 32'hFFFF_FFFF);
    check("R5 pin_o unchanged", 32'(po_rise), 32'h3C);
    check("R5 pin_oe_o unchanged", 32'(oe_rise), 32'h5A);
    rd(5'h08); check("R5 mask unchanged", v_rise, 32'h0);
    rd(5'h10); check("R5 read hole", v_rise, 32'h0);
    rd(5'h14); check("R5 read hole", v_lvl, 32'h0);

    // R6 per-pin edge sweep
    for (int i = 0; i < NP; i++) begin
      @(negedge clk);
      pins[i] = 1'b1;
      repeat (2) @(negedge clk);
      caps("R6 rising", 32'(1) << i, 32'h0, 32'(1) << i);
      wr(5'h0C, 32'(1) << i);
      caps("R7 clear one", 32'h0, 32'h0, 32'h0);
      @(negedge clk);
      pins[i] = 1'b0;
      repeat (2) @(negedge clk);
      caps("R6 falling", 32'h0, 32'(1) << i, 32'(1) << i);
      wr(5'h0C, 32'hFF);
    end

    // R6 capture latency: not yet after two edges
    @(negedge clk);
    pins = 8'h01;
    @(negedge clk);
    rd(5'h0C); check("R6 latency two edges", v_rise, 32'h0);
    rd(5'h0C); check("R6 latency three edges", v_rise, 32'h1);
    clear_all();

    // R7 partial clear
    @(negedge clk);
    pins = 8'hF0;
    repeat (2) @(negedge clk);
    caps("R6 multi pin", 32'hF0, 32'h0, 32'hF0);
    wr(5'h0C, 32'h30);
    caps("R7 partial clear", 32'hC0, 32'h0, 32'hC0);
    wr(5'h0C, 32'h0);
    caps("R7 zero write keeps", 32'hC0, 32'h0, 32'hC0);

    // R11 masked
    check("R11 rise irq masked", 32'(irq_rise), 32'h0);
    check("R11 level irq masked", 32'(irq_lvl), 32'h0);
    // R9 / R10
    wr(5'h08, 32'h40);
    check("R9 rise irq", 32'(irq_rise), 32'h1);
    check("R9 both irq", 32'(irq_both), 32'h1);
    check("R9 fall irq", 32'(irq_fall), 32'h0);
    check("R10 level irq", 32'(irq_lvl), 32'h1);
    wr(5'h08, 32'h01);
    check("R9 rise irq other bit", 32'(irq_rise), 32'h0);
    check("R10 level irq pin low", 32'(irq_lvl), 32'h0);
    @(negedge clk);
    pins = 8'hF1;
    @(negedge clk);
    @(negedge clk);
    check("R10 level irq after sync", 32'(irq_lvl), 32'h1);
    check("R9 rise irq before capture", 32'(irq_rise), 32'h0);
    @(negedge clk);
    check("R9 rise irq after capture", 32'(irq_rise), 32'h1);
    wr(5'h0C, 32'h01);
    check("R9 rise irq cleared", 32'(irq_rise), 32'h0);
    wr(5'h08, 32'h0);
    clear_all();

    // R8 event and clear on the same edge
    @(negedge clk);
    pins = 8'h04;
    repeat (2) @(negedge clk);
    caps("R8 setup", 32'h04, 32'h0, 32'h04);
    @(negedge clk);
    pins = 8'h00;
    @(negedge clk);
    wr(5'h0C, 32'h04);
    caps("R8 collision", 32'h0, 32'h04, 32'h04);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule